// File: doc/BRIEF.md
# Defect-Triggered E1 Alarm Insertion Controller

This block sits between a bank of E1 transmit framers and their line outputs. It replaces every tributary stream with the alarm indication signal (continuous ones) while the upstream SDH receive overhead monitor reports a serious defect. Five defect flags can start insertion: signal fail, signal degrade, loss of signal, loss of frame, and line-level AIS. One configuration enable bit turns the function on or off for all channels together. Insertion lasts as long as at least one of the flags stays declared.

Each channel carries its own serial bit stream with its own bit strobe. Each channel also keeps a count of the bit position within its 256-bit E1 frame. A channel switches between passing data through and sending ones only at a frame boundary, so no frame is cut short. The defect flags come from another clock domain, so each flag passes through a two-flop synchronizer before the block uses it. A per-channel status output shows which channels are sending the alarm pattern.

Top module: `e1_ais_inserter`

## Requirements
- R1: With the enable high, any single one of the five synchronized defect flags puts every channel into alarm insertion at that channel's next frame boundary.
- R2: With the enable low at a channel's frame boundary, that channel leaves that boundary with alarm insertion off, whatever the defect flags are.
- R3: Insertion stays on while any synchronized defect is declared with the enable high. It turns off at the first frame boundary after all five flags have cleared.
- R4: A channel's alarm status changes only on the clock edge of a bit strobe at which the channel's bit counter holds FRAME_BITS-1 (the last bit of a frame). The new state applies from the first bit of the next frame.
- R5: While a channel's alarm status is high, its data output is 1. While the status is low, the data output equals that channel's data input in the same cycle.
- R6: Each defect flag goes through two flip-flops before it affects the decision. A flag value present at clock edge k is used by a boundary decision at edge k+2.
- R7: After reset, every bit counter is 0, every alarm status is 0, and both synchronizer stages are 0.
- R8: A channel's bit counter advances by one only on clock edges where that channel's bit strobe is high. It wraps from FRAME_BITS-1 to 0, so a frame spans FRAME_BITS strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than any tributary bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_auto_ais_en | input | 1 | Global enable for automatic alarm insertion |
| dfct_sf | input | 1 | Signal fail flag, asynchronous |
| dfct_sd | input | 1 | Signal degrade flag, asynchronous |
| dfct_los | input | 1 | Loss of signal flag, asynchronous |
| dfct_lof | input | 1 | Loss of frame flag, asynchronous |
| dfct_line_ais | input | 1 | Line AIS flag, asynchronous |
| bit_stb | input | NUM_CH | Per-channel bit strobe, one clock wide per tributary bit |
| tx_data_in | input | NUM_CH | Per-channel framer serial data |
| tx_data_out | output | NUM_CH | Per-channel serial data after alarm substitution |
| ais_active | output | NUM_CH | Per-channel alarm insertion status |

## Verification
A bit counter that is out of place shows at the ports as an alarm status that switches on the wrong strobe. A reference model that tracks each channel's frame position sees this at the first boundary after the bad count, which is at most one frame of strobes later. An error in the synchronizer depth or in the defect combination shows as a status that switches one frame early or late, or never switches. The bench drives each defect flag by itself and compares every channel on every clock. An error in the output multiplexer shows in the same cycle as a data bit that differs from the input while the status is low, or a zero while the status is high.

// File: rtl/e1_ais_pkg.sv
package e1_ais_pkg;

  localparam int unsigned DEFECT_COUNT = 5;

  // Bit order inside the vector is local to this block only.
  typedef struct packed {
    logic line_ais;
    logic lof;
    logic los;
    logic sd;
    logic sf;
  } defect_set_t;

  // True when at least one defect flag is declared.
  function automatic logic any_defect(input defect_set_t d);
    return |d;
  endfunction

  // Insertion request: the global enable gates the defect summary.
  function automatic logic insert_request(input logic enable, input defect_set_t d);
    return enable & any_defect(d);
  endfunction

endpackage

// File: rtl/defect_sync.sv
module defect_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ais_request.sv
module ais_request
  import e1_ais_pkg::*;
(
  input  logic        enable,
  input  defect_set_t defects_sync,
  output logic        req
);

  always_comb begin
    req = insert_request(enable, defects_sync);
  end

endmodule

// File: rtl/ais_channel.sv
module ais_channel #(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic req,
  input  logic din,
  output logic dout,
  output logic ais,
  output logic frame_end
);

  localparam int unsigned CW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

  logic [CW-1:0] bit_pos;

  // Counter step: wrap at the frame's last bit.
  function automatic logic [CW-1:0] next_pos(input logic [CW-1:0] p);
    return (p == LAST_BIT) ? '0 : p + 1'b1;
  endfunction

  assign frame_end = bit_stb && (bit_pos == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos <= '0;
      ais     <= 1'b0;
    end else begin
      if (bit_stb)   bit_pos <= next_pos(bit_pos);
      if (frame_end) ais     <= req;
    end
  end

  always_comb begin
    dout = ais ? 1'b1 : din;
  end

endmodule

// File: rtl/e1_ais_inserter.sv
module e1_ais_inserter
  import e1_ais_pkg::*;
#(
  parameter int unsigned NUM_CH      = 28,
  parameter int unsigned FRAME_BITS  = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_ais_en,
  input  logic              dfct_sf,
  input  logic              dfct_sd,
  input  logic              dfct_los,
  input  logic              dfct_lof,
  input  logic              dfct_line_ais,
  input  logic [NUM_CH-1:0] bit_stb,
  input  logic [NUM_CH-1:0] tx_data_in,
  output logic [NUM_CH-1:0] tx_data_out,
  output logic [NUM_CH-1:0] ais_active
);

  defect_set_t       defects_raw;
  defect_set_t       defects_sync;
  logic              ais_req;
  logic [NUM_CH-1:0] frame_end;

  assign defects_raw = '{line_ais: dfct_line_ais, lof: dfct_lof, los: dfct_los,
                         sd: dfct_sd, sf: dfct_sf};

  defect_sync #(
    .WIDTH  (DEFECT_COUNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (defects_raw),
    .sync_out (defects_sync)
  );

  ais_request u_req (
    .enable       (cfg_auto_ais_en),
    .defects_sync (defects_sync),
    .req          (ais_req)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ais_channel #(
        .FRAME_BITS (FRAME_BITS)
      ) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb[c]),
        .req       (ais_req),
        .din       (tx_data_in[c]),
        .dout      (tx_data_out[c]),
        .ais       (ais_active[c]),
        .frame_end (frame_end[c])
      );
    end
  endgenerate

endmodule

// File: rtl/e1_ais_inserter_chk.sv
module e1_ais_inserter_chk #(
  parameter int unsigned NUM_CH = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [4:0]        raw,
  input logic              req,
  input logic [NUM_CH-1:0] frame_end,
  input logic [NUM_CH-1:0] data_in,
  input logic [NUM_CH-1:0] data_out,
  input logic [NUM_CH-1:0] ais
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (req == (en && (|$past(raw, 2))))); // R6

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ast
      AST_ONES_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ais[c] |-> data_out[c]); // R5
      AST_PASS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ais[c] |-> (data_out[c] == data_in[c])); // R5
      AST_SWITCH_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end[c] |=> $stable(ais[c])); // R4
      AST_ENABLE_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end[c] && !en) |=> !ais[c]); // R2
      AST_DEFECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end[c] && req) |=> ais[c]); // R1
    end
  endgenerate

endmodule

bind e1_ais_inserter e1_ais_inserter_chk #(
  .NUM_CH (NUM_CH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (cfg_auto_ais_en),
  .raw       ({dfct_line_ais, dfct_lof, dfct_los, dfct_sd, dfct_sf}),
  .req       (ais_req),
  .frame_end (frame_end),
  .data_in   (tx_data_in),
  .data_out  (tx_data_out),
  .ais       (ais_active)
);

// File: tb/e1_ais_inserter_bench.sv
`timescale 1ns/1ps
module e1_ais_inserter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 28;
  localparam int FRAME_BITS = 256;
  localparam int SETTLE     = 2000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [4:0]        dfct = '0;  // [0]=sf [1]=sd [2]=los [3]=lof [4]=line_ais
  logic [NUM_CH-1:0] stb = '0;
  logic [NUM_CH-1:0] din = '0;
  logic [NUM_CH-1:0] dout;
  logic [NUM_CH-1:0] ais;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_ais_inserter #(.NUM_CH(NUM_CH), .FRAME_BITS(FRAME_BITS)) u_e1_ais_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_auto_ais_en(en),
    .dfct_sf(dfct[0]), .dfct_sd(dfct[1]), .dfct_los(dfct[2]),
    .dfct_lof(dfct[3]), .dfct_line_ais(dfct[4]),
    .bit_stb(stb), .tx_data_in(din), .tx_data_out(dout), .ais_active(ais)
  );

  // Reference model: frame position and alarm state per channel, delay line for flags.
  int m_pos [NUM_CH];
  bit m_ais [NUM_CH];
  bit m_d1, m_d2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin m_pos[c] = 0; m_ais[c] = 0; end
      m_d1 = 0; m_d2 = 0;
    end else begin
      bit want;
      want = en && m_d2;
      for (int c = 0; c < NUM_CH; c++) begin
        if (stb[c]) begin
          if (m_pos[c] == FRAME_BITS - 1) begin
            m_ais[c] = want;
            m_pos[c] = 0;
          end else begin
            m_pos[c] = m_pos[c] + 1;
          end
        end
      end
      m_d2 = m_d1;
      m_d1 = |dfct;
    end
  end

  // Stimulus for strobes and data: channel c strobes every 1..3 clocks.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < NUM_CH; c++) begin
      stb[c] = ((cyc % (1 + c % 3)) == 0);
      din[c] = $urandom_range(0, 1);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison, a quarter period after the falling edge.
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    for (int c = 0; c < NUM_CH; c++) begin
      check(ais[c] == m_ais[c], $sformatf("R1 R3 R4 R6 R8 status ch%0d", c), ais[c], m_ais[c]);
      check(dout[c] == (m_ais[c] ? 1'b1 : din[c]), $sformatf("R5 data ch%0d", c),
            dout[c], m_ais[c] ? 1 : din[c]);
    end
  end

  task automatic all_status(input bit exp, input string tag);
    @(negedge clk);
    #(CLK_PERIOD/4);
    for (int c = 0; c < NUM_CH; c++)
      check(ais[c] == exp, $sformatf("%s ch%0d", tag, c), ais[c], exp);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cycles(5);
    all_status(1'b0, "R7 reset status");
    rst_n = 1'b1;
    wait_cycles(3);
    all_status(1'b0, "R7 after release");
    // Enable low: defects ignored.
    dfct = 5'b00001;
    wait_cycles(SETTLE);
    all_status(1'b0, "R2 enable low");
    dfct = '0;
    en = 1'b1;
    // Each defect by itself.
    for (int d = 0; d < 5; d++) begin
      dfct = 5'(1 << d);
      wait_cycles(SETTLE);
      all_status(1'b1, $sformatf("R1 defect bit %0d", d));
      dfct = '0;
      wait_cycles(SETTLE);
      all_status(1'b0, $sformatf("R3 cleared bit %0d", d));
    end
    // Enable dropped while the defect persists.
    dfct = 5'b00100;
    wait_cycles(SETTLE);
    all_status(1'b1, "R1 before disable");
    en = 1'b0;
    wait_cycles(SETTLE);
    all_status(1'b0, "R2 disabled mid-defect");
    // Two defects overlapping.
    en = 1'b1;
    dfct = 5'b11000;
    wait_cycles(SETTLE);
    dfct = 5'b10000;
    wait_cycles(SETTLE);
    all_status(1'b1, "R3 one defect left");
    dfct = '0;
    wait_cycles(SETTLE);
    all_status(1'b0, "R3 all clear");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule